// File: doc/BRIEF.md
# Packed SIMD Narrowing Pack Unit

This block takes two 64-bit packed operands from a multimedia register file of eight 64-bit registers. It narrows every lane of both operands to half its width and joins the narrowed lanes into one 64-bit result. Two widths are supported. In word-to-byte packing, the four 16-bit lanes of each operand become eight bytes. In doubleword-to-word packing, the two 32-bit lanes of each operand become four 16-bit words.

Each lane is narrowed in one of three ways. Truncation keeps the low bits. Signed saturation clamps the value to the signed range of the narrow type. Unsigned saturation reads the input lane as signed and clamps it to the unsigned range of the narrow type.

The "low" operand is the register that the result will overwrite. Its narrowed lanes fill the low half of the result. The "high" operand fills the upper half. The result is registered and appears one clock after an accepted request, together with its own valid flag.

Top module: `simd_pack_unit`

## Requirements
- R1: With `in_op`=0 (word to byte), byte k of `out_data` (bits 8k+7..8k) is the narrowed 16-bit lane k of the pair {hi_opnd, lo_opnd}. Bytes 0..3 therefore come from `lo_opnd` lanes 0..3, and bytes 4..7 come from `hi_opnd` lanes 0..3.
- R2: With `in_op`=1 (doubleword to word), word k of `out_data` (bits 16k+15..16k) is the narrowed 32-bit lane k of {hi_opnd, lo_opnd}. Words 0..1 come from `lo_opnd`, and words 2..3 come from `hi_opnd`.
- R3: With `in_mode`=0 or 3 (truncate), each output lane equals the low bits of its input lane, with no clamping.
- R4: With `in_mode`=1 (signed saturate) and `in_op`=0, each input word is read as signed. Values above 127 give 0x7F, values below -128 give 0x80, and all other values give their low byte.
- R5: With `in_mode`=2 (unsigned saturate) and `in_op`=0, each input word is read as signed. Negative values give 0x00, values above 255 give 0xFF, and all other values give their low byte.
- R6: With `in_op`=1, the same rules apply with 16-bit limits. Signed saturation clamps to 0x7FFF or 0x8000. Unsigned saturation clamps to 0x0000 or 0xFFFF.
- R7: When `in_valid` is high at a rising edge, `out_valid` is high after that edge and `out_data` holds that request's result.
- R8: When `in_valid` is low at a rising edge, `out_valid` is low after that edge and `out_data` keeps its previous value.
- R9: A synchronous active-low reset (`rst_n`=0 at a rising edge) clears `out_valid` and `out_data` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_op | input | 1 | 0: word to byte, 1: doubleword to word |
| in_mode | input | 2 | 0/3: truncate, 1: signed saturate, 2: unsigned saturate |
| lo_opnd | input | 64 | Operand placed in the low half (the overwritten register) |
| hi_opnd | input | 64 | Operand placed in the high half |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_data | output | 64 | Packed result |

## Verification
Every result is due exactly one rising edge after the request edge, because there is a single output register. The bench changes inputs on the falling edge. It samples `out_valid` and `out_data` on the following falling edge, which falls between the result edge and the next edge. One cycle later it samples again to confirm that the valid flag has dropped and the data has held. A back-to-back pair of requests confirms that each result lands in its own cycle. Reset is checked both at start-up and while a result is being held.

// File: rtl/pack_pkg.sv
// Shared definitions for the packed narrowing unit.
// Assumes a 64-bit multimedia register width.
package pack_pkg;
    localparam int REG_W = 64;

    typedef enum logic [1:0] {
        MODE_TRUNC  = 2'd0,
        MODE_SSAT   = 2'd1,
        MODE_USAT   = 2'd2,
        MODE_TRUNC2 = 2'd3
    } sat_mode_e;

    typedef enum logic {
        OP_W2B = 1'b0,
        OP_D2W = 1'b1
    } pack_op_e;
endpackage

// File: rtl/lane_narrow.sv
// Narrows one IN_W-bit lane to OUT_W bits by truncation or by signed or
// unsigned saturation. The input lane is always read as a signed value.
// Assumes OUT_W < IN_W.
module lane_narrow #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 8
) (
    input  logic [IN_W-1:0]      lane_in,
    input  pack_pkg::sat_mode_e  mode,
    output logic [OUT_W-1:0]     lane_out
);
    localparam int TOP_W = IN_W - OUT_W + 1;

    logic [TOP_W-1:0] top_bits;
    logic             sign_bit;
    logic             fits_signed;
    logic             fits_unsigned;
    logic [OUT_W-1:0] low_bits;

    // Range detection: signed fit means all discarded bits equal the new sign bit.
    always_comb begin
        top_bits      = lane_in[IN_W-1:OUT_W-1];
        sign_bit      = lane_in[IN_W-1];
        fits_signed   = (&top_bits) | ~(|top_bits);
        fits_unsigned = ~(|lane_in[IN_W-1:OUT_W]);
        low_bits      = lane_in[OUT_W-1:0];
    end

    // Select the clamped or truncated value for the requested mode.
    always_comb begin
        case (mode)
            pack_pkg::MODE_SSAT: begin
                if (fits_signed)   lane_out = low_bits;
                else if (sign_bit) lane_out = {1'b1, {(OUT_W-1){1'b0}}};
                else               lane_out = {1'b0, {(OUT_W-1){1'b1}}};
            end
            pack_pkg::MODE_USAT: begin
                if (fits_unsigned) lane_out = low_bits;
                else if (sign_bit) lane_out = '0;
                else               lane_out = '1;
            end
            default: lane_out = low_bits;
        endcase
    end
endmodule

// File: rtl/narrow_bank.sv
// Narrows every lane of the operand pair {hi, lo} and concatenates the
// results in lane order, so lanes of lo land in the low half.
// Assumes REG_W is a multiple of IN_W.
module narrow_bank #(
    parameter int REG_W = 64,
    parameter int IN_W  = 16
) (
    input  logic [REG_W-1:0]     lo_opnd,
    input  logic [REG_W-1:0]     hi_opnd,
    input  pack_pkg::sat_mode_e  mode,
    output logic [REG_W-1:0]     packed_out
);
    localparam int OUT_W = IN_W / 2;
    localparam int LANES = (2 * REG_W) / IN_W;

    logic [2*REG_W-1:0] pair;

    // Join the operands so lane index maps straight to output position.
    always_comb pair = {hi_opnd, lo_opnd};

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        lane_narrow #(.IN_W(IN_W), .OUT_W(OUT_W)) u_lane (
            .lane_in  (pair[i*IN_W +: IN_W]),
            .mode     (mode),
            .lane_out (packed_out[i*OUT_W +: OUT_W])
        );
    end
endmodule

// File: rtl/simd_pack_unit.sv
// Top of the narrowing pack unit. Two lane banks (16->8 and 32->16)
// work in parallel, the operation select chooses one, and a single
// register stage gives a one-cycle latency. Assumes synchronous
// active-low reset.
module simd_pack_unit #(
    parameter int REG_W = pack_pkg::REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_op,
    input  logic [1:0]       in_mode,
    input  logic [REG_W-1:0] lo_opnd,
    input  logic [REG_W-1:0] hi_opnd,
    output logic             out_valid,
    output logic [REG_W-1:0] out_data
);
    pack_pkg::sat_mode_e mode;
    logic [REG_W-1:0]    w2b_res;
    logic [REG_W-1:0]    d2w_res;
    logic [REG_W-1:0]    next_res;

    // Decode the mode field into the shared enum.
    always_comb mode = pack_pkg::sat_mode_e'(in_mode);

    narrow_bank #(.REG_W(REG_W), .IN_W(16)) u_w2b (
        .lo_opnd    (lo_opnd),
        .hi_opnd    (hi_opnd),
        .mode       (mode),
        .packed_out (w2b_res)
    );

    narrow_bank #(.REG_W(REG_W), .IN_W(32)) u_d2w (
        .lo_opnd    (lo_opnd),
        .hi_opnd    (hi_opnd),
        .mode       (mode),
        .packed_out (d2w_res)
    );

    // Pick the bank result for the requested operation.
    always_comb next_res = (in_op == pack_pkg::OP_D2W) ? d2w_res : w2b_res;

    // Output stage: capture on a valid request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= next_res;
        end
    end
endmodule

// File: rtl/simd_pack_checks.sv
// Protocol and lane-rule checks for simd_pack_unit, attached by bind.
module simd_pack_checks #(
    parameter int REG_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_op,
    input logic [1:0]       in_mode,
    input logic [REG_W-1:0] lo_opnd,
    input logic [REG_W-1:0] hi_opnd,
    input logic             out_valid,
    input logic [REG_W-1:0] out_data
);
    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R7

    AST_IDLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R8

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data)); // R8

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0)); // R9

    AST_USAT_NEG_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 1'b0 && in_mode == 2'd2 && lo_opnd[15]) |=> out_data[7:0] == 8'h00); // R5

    AST_USAT_NEG_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 1'b1 && in_mode == 2'd2 && hi_opnd[31]) |=> out_data[47:32] == 16'h0000); // R6

    AST_SAME_HALVES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lo_opnd == hi_opnd) |=> out_data[REG_W/2-1:0] == out_data[REG_W-1:REG_W/2]); // R1
endmodule

bind simd_pack_unit simd_pack_checks #(.REG_W(REG_W)) u_chk (.*);

// File: tb/tb_simd_pack_unit.sv
module tb_simd_pack_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_op;
    logic [1:0]  in_mode;
    logic [63:0] lo_opnd;
    logic [63:0] hi_opnd;
    logic        out_valid;
    logic [63:0] out_data;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    simd_pack_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_mode(in_mode), .lo_opnd(lo_opnd), .hi_opnd(hi_opnd),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [15:0] narrow_ref(logic [31:0] v, int iw, int ow, logic [1:0] m);
        longint sv, lo, hi, mask;
        mask = (64'sd1 <<< ow) - 1;
        if (iw == 16) sv = longint'($signed(v[15:0]));
        else          sv = longint'($signed(v[31:0]));
        if (m == 2'd1) begin
            lo = -(64'sd1 <<< (ow - 1));
            hi = (64'sd1 <<< (ow - 1)) - 1;
        end else if (m == 2'd2) begin
            lo = 0;
            hi = mask;
        end else begin
            return 16'(sv & mask);
        end
        if (sv < lo) sv = lo;
        if (sv > hi) sv = hi;
        return 16'(sv & mask);
    endfunction

    function automatic logic [63:0] pack_ref(logic op, logic [1:0] m, logic [63:0] lo, logic [63:0] hi);
        logic [127:0] pr;
        logic [63:0]  r;
        logic [15:0]  t;
        pr = {hi, lo};
        r  = '0;
        if (op == 1'b0) begin
            for (int i = 0; i < 8; i++) begin
                t = narrow_ref({16'h0, pr[16*i +: 16]}, 16, 8, m);
                r[8*i +: 8] = t[7:0];
            end
        end else begin
            for (int i = 0; i < 4; i++)
                r[16*i +: 16] = narrow_ref(pr[32*i +: 32], 32, 16, m);
        end
        return r;
    endfunction

    function automatic string tag_of(logic op, logic [1:0] m);
        string s;
        s = (op == 1'b0) ? "R1" : "R2";
        if (m == 2'd1)      s = {s, (op == 1'b0) ? " R4" : " R6"};
        else if (m == 2'd2) s = {s, (op == 1'b0) ? " R5" : " R6"};
        else                s = {s, " R3"};
        return s;
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(logic op, logic [1:0] m, logic [63:0] lo, logic [63:0] hi);
        in_valid = 1'b1;
        in_op    = op;
        in_mode  = m;
        lo_opnd  = lo;
        hi_opnd  = hi;
    endtask

    // One request, then one idle cycle to check hold behaviour.
    task automatic apply(logic op, logic [1:0] m, logic [63:0] lo, logic [63:0] hi);
        logic [63:0] exp;
        exp = pack_ref(op, m, lo, hi);
        @(negedge clk);
        drive(op, m, lo, hi);
        @(negedge clk);
        in_valid = 1'b0;
        lo_opnd  = ~lo;
        chk(out_valid === 1'b1, "R7 valid", {63'h0, out_valid}, 64'h1);
        chk(out_data === exp, tag_of(op, m), out_data, exp);
        @(negedge clk);
        chk(out_valid === 1'b0, "R8 valid", {63'h0, out_valid}, 64'h0);
        chk(out_data === exp, "R8 hold", out_data, exp);
    endtask

    function automatic logic [15:0] pick_chunk();
        case ($urandom_range(9, 0))
            0: return 16'h007F;
            1: return 16'h0080;
            2: return 16'hFF80;
            3: return 16'hFF7F;
            4: return 16'h8000;
            5: return 16'h7FFF;
            6: return 16'h00FF;
            7: return 16'h0100;
            default: return 16'($urandom);
        endcase
    endfunction

    function automatic logic [63:0] pick_opnd();
        return {pick_chunk(), pick_chunk(), pick_chunk(), pick_chunk()};
    endfunction

    initial begin
        #(8 * 200000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [63:0] e1, e2;
        void'($urandom(32'h5EED1234));
        rst_n = 1'b0; in_valid = 1'b0; in_op = 1'b0; in_mode = 2'd0;
        lo_opnd = '0; hi_opnd = '0;
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0, "R9 reset valid", {63'h0, out_valid}, 64'h0);
        chk(out_data === 64'h0, "R9 reset data", out_data, 64'h0);
        rst_n = 1'b1;

        // Directed lane-order and boundary cases.
        apply(1'b0, 2'd0, 64'h4444_3333_2222_1111, 64'h8888_7777_6666_5555);      // R1 R3
        apply(1'b1, 2'd3, 64'h2222_2222_1111_1111, 64'h4444_4444_3333_3333);      // R2 R3
        apply(1'b0, 2'd1, 64'h0080_FF7F_007F_FF80, 64'h8000_7FFF_0000_FFFF);      // R4
        apply(1'b0, 2'd2, 64'h0100_00FF_FFFF_0000, 64'h8000_7FFF_0080_0001);      // R5
        apply(1'b1, 2'd1, 64'hFFFF_7FFF_0000_8000, 64'h8000_0000_7FFF_FFFF);      // R6
        apply(1'b1, 2'd2, 64'h0001_0000_0000_FFFF, 64'hFFFF_FFFF_0000_8000);      // R6

        // Back-to-back requests: each result due one edge after its own request (R7).
        e1 = pack_ref(1'b0, 2'd1, 64'h1234_5678_9ABC_DEF0, 64'h0F0F_F0F0_00FF_FF00);
        e2 = pack_ref(1'b1, 2'd2, 64'h0001_2345_FFFF_0000, 64'h7FFF_FFFF_0000_1234);
        @(negedge clk);
        drive(1'b0, 2'd1, 64'h1234_5678_9ABC_DEF0, 64'h0F0F_F0F0_00FF_FF00);
        @(negedge clk);
        chk(out_data === e1, "R7 first of pair", out_data, e1);
        drive(1'b1, 2'd2, 64'h0001_2345_FFFF_0000, 64'h7FFF_FFFF_0000_1234);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid === 1'b1, "R7 second valid", {63'h0, out_valid}, 64'h1);
        chk(out_data === e2, "R7 second of pair", out_data, e2);

        // Constrained random mix.
        for (int k = 0; k < 400; k++)
            apply(1'($urandom_range(1, 0)), 2'($urandom_range(3, 0)), pick_opnd(), pick_opnd());

        // Reset while a result is held (R9).
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(out_valid === 1'b0, "R9 mid-run valid", {63'h0, out_valid}, 64'h0);
        chk(out_data === 64'h0, "R9 mid-run data", out_data, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule